// File: doc/BRIEF.md
# CPU Frame Mailbox Port

This block is the path between a host processor and the switch fabric for whole frames. The host reaches it through a narrow byte-wide register window. Two byte registers in that window carry frames. Address `3'b011` is the frame port and address `3'b111` is the control-frame port.

To send a frame, the host writes a four-byte header to the frame port and then the payload bytes. The block keeps the payload in a local buffer. When the buffer holds the whole frame, the block streams it to the forwarding side one byte per cycle. Once streamed, the frame is an ordinary frame; no marker of its origin is kept.

In the receive direction, the fabric pushes a frame into one of two receive buffers: a standard buffer or a 40-byte control buffer. The block then raises `host_irq`. The host reads a five-byte header from the matching register, then reads as many payload bytes as the size field gives.

The transmit assembler has three states:
- `TX_HDR`: collecting the header.
- `TX_PAY`: collecting the payload.
- `TX_SEND`: streaming the frame out.

Its transitions are:
- `TX_HDR` to `TX_PAY` on the fourth header byte when the size is non-zero.
- `TX_HDR` to `TX_SEND` on the fourth header byte when the size is zero.
- `TX_PAY` to `TX_SEND` on the last payload byte.
- `TX_SEND` to `TX_HDR` on the last output byte.

Each receive presenter has three states:
- `RX_EMPTY`: waiting for a frame.
- `RX_FILL`: loading a frame.
- `RX_PEND`: a frame is waiting for the host.

Its transitions are:
- `RX_EMPTY` to `RX_FILL` on a first byte that is not the last byte.
- `RX_EMPTY` to `RX_PEND` on a one-byte frame.
- `RX_FILL` to `RX_PEND` on the last byte.
- `RX_PEND` to `RX_EMPTY` when the host reads the final payload byte.

Top module: `mbx_cpu_frame_port`

## Requirements
- R1: After reset, the outputs are as follows:
  - `host_irq`, `fwd_valid`, `data_underrun` and `ctrl_underrun` are low.
  - `sw_ready` and `cf_ready` are high.
  - `host_rdata` is zero.
- R2: Host writes to address 3 are taken in this order:
  - frame size low byte, then frame size high byte;
  - destination port (low 3 bits);
  - status byte;
  - then exactly `size` payload bytes.
  
  From the cycle after the last payload byte, the frame leaves on `fwd_data` one byte per cycle, in write order. `fwd_valid` stays high for the whole frame. `fwd_port` and `fwd_status` hold the header values, and `fwd_last` marks the final byte.
- R3: A transmitted frame whose size is below 64 leaves as exactly 64 bytes: the payload, then zero bytes. A size of 0 gives 64 zero bytes.
- R4: Writes to address 3 while a frame is streaming out have no effect. Writes to address 7 or to any other address have no effect. The next frame written afterwards is forwarded unchanged.
- R5: A fabric frame is pushed with `sw_valid` and ends with `sw_last`. `sw_port` and `sw_vlan` are taken on the first byte. After the last byte, `host_irq` is high and `sw_ready` is low.
- R6: A host read takes effect on the next clock edge. Reads of address 3 return, in order:
  - size low byte, then size high byte;
  - source port;
  - VLAN low byte, then VLAN high byte;
  - then the payload bytes in arrival order.
  
  A read of an unmapped address returns 0.
- R7: `host_irq` stays high until the last payload byte of the pending frame is read. It then falls and `sw_ready` rises. A frame pushed after that raises `host_irq` again.
- R8: A read of address 3 or address 7 with no pending frame returns 0 and sets the matching sticky status bit (`data_underrun` or `ctrl_underrun`). Only reset clears these bits.
- R9: Control frames use address 7 with the same five-byte header, and their VLAN bytes read as 0. At most 40 bytes are kept. Extra bytes are dropped, and the size field then reads 40.
- R10: `host_irq` is high while either the standard buffer or the control buffer holds a pending frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after the strobe |
| host_irq | output | 1 | Receive frame pending |
| data_underrun | output | 1 | Sticky: frame port read while empty |
| ctrl_underrun | output | 1 | Sticky: control port read while empty |
| fwd_valid | output | 1 | Outgoing byte valid |
| fwd_data | output | 8 | Outgoing byte |
| fwd_last | output | 1 | Final outgoing byte |
| fwd_port | output | 3 | Destination port of outgoing frame |
| fwd_status | output | 8 | Status byte of outgoing frame |
| sw_valid | input | 1 | Fabric frame byte valid |
| sw_data | input | 8 | Fabric frame byte |
| sw_last | input | 1 | Final fabric frame byte |
| sw_port | input | 3 | Source port, taken on first byte |
| sw_vlan | input | 16 | VLAN tag, taken on first byte |
| sw_ready | output | 1 | Standard receive buffer can accept |
| cf_valid | input | 1 | Control frame byte valid |
| cf_data | input | 8 | Control frame byte |
| cf_last | input | 1 | Final control frame byte |
| cf_port | input | 3 | Control frame source port |
| cf_ready | output | 1 | Control buffer can accept |

## Verification
The transmit path is tried with three payload lengths: one above the 64-byte floor, one below it, and zero. Together they separate plain copying from zero padding and from the header-only path. A frame is sent after junk writes that land during streaming or at the control address; it shows whether stray writes are taken as a new header. On receive, a 12-byte frame, a 3-byte frame and a 45-byte control frame separate header order, interrupt release and the 40-byte cap. Standard and control frames pending at the same time show that either one holds the interrupt. Empty reads at each address show which underrun bit is set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int TX_HDR_BYTES = 4;
    localparam int RX_HDR_BYTES = 5;

    typedef enum logic [1:0] {TX_HDR, TX_PAY, TX_SEND} tx_state_e;
    typedef enum logic [1:0] {RX_EMPTY, RX_FILL, RX_PEND} rx_state_e;
endpackage

// File: rtl/mbx_tx_assembler.sv
module mbx_tx_assembler
    import mbx_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int MIN_LEN = 64,
    parameter int PORT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic              fwd_valid,
    output logic [7:0]        fwd_data,
    output logic              fwd_last,
    output logic [PORT_W-1:0] fwd_port,
    output logic [7:0]        fwd_status
);
    localparam int AW = $clog2(DEPTH);
    localparam int IW = $clog2(DEPTH + 1);

    tx_state_e         state, nxt;
    logic [1:0]        hdr_cnt;
    logic [7:0]        size_lo;
    logic [IW-1:0]     len_q, wcnt, sidx, out_len;
    logic [PORT_W-1:0] port_q;
    logic [7:0]        status_q;
    logic [7:0]        mem [DEPTH];
    logic [15:0]       full_size;

    assign full_size = {wdata, size_lo};
    assign out_len   = (len_q < IW'(MIN_LEN)) ? IW'(MIN_LEN) : len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_HDR;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        fwd_valid  = 1'b0;
        fwd_last   = 1'b0;
        fwd_data   = 8'h00;
        unique case (state)
            TX_HDR:  if (wr && hdr_cnt == 2'd3) nxt = (len_q == '0) ? TX_SEND : TX_PAY;
            TX_PAY:  if (wr && wcnt == len_q - IW'(1)) nxt = TX_SEND;
            TX_SEND: begin
                fwd_valid = 1'b1;
                fwd_last  = (sidx == out_len - IW'(1));
                fwd_data  = (sidx < len_q) ? mem[sidx[AW-1:0]] : 8'h00;
                if (fwd_last) nxt = TX_HDR;
            end
            default: nxt = TX_HDR;
        endcase
    end

    assign fwd_port   = port_q;
    assign fwd_status = status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_cnt  <= '0;
            size_lo  <= '0;
            len_q    <= '0;
            port_q   <= '0;
            status_q <= '0;
            wcnt     <= '0;
            sidx     <= '0;
        end else begin
            if (state == TX_HDR && wr) begin
                hdr_cnt <= hdr_cnt + 2'd1;
                unique case (hdr_cnt)
                    2'd0: size_lo <= wdata;
                    2'd1: len_q <= (full_size > 16'(DEPTH)) ? IW'(DEPTH) : full_size[IW-1:0];
                    2'd2: port_q <= wdata[PORT_W-1:0];
                    default: status_q <= wdata;
                endcase
            end
            if (state == TX_PAY && wr) wcnt <= wcnt + IW'(1);
            else if (state != TX_PAY)  wcnt <= '0;
            if (state == TX_SEND) sidx <= sidx + IW'(1);
            else                  sidx <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (state == TX_PAY && wr) mem[wcnt[AW-1:0]] <= wdata;
    end

    assert_burst_unbroken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_last |=> fwd_valid);
    assert_header_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_last |=> $stable(fwd_port) && $stable(fwd_status));
    assert_send_ignores_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && wr |=> $stable(len_q) && $stable(hdr_cnt));
endmodule

// File: rtl/mbx_rx_presenter.sv
module mbx_rx_presenter
    import mbx_pkg::*;
#(
    parameter int MAX_LEN = 256,
    parameter int PORT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [PORT_W-1:0] in_port,
    input  logic [15:0]       in_vlan,
    output logic              in_ready,
    input  logic              rd,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic              underrun
);
    localparam int AW = $clog2(MAX_LEN);
    localparam int IW = $clog2(MAX_LEN + RX_HDR_BYTES + 1);

    rx_state_e         state, nxt;
    logic [IW-1:0]     len_q, idx, pidx;
    logic [PORT_W-1:0] port_q;
    logic [15:0]       vlan_q, size16;
    logic [7:0]        mem [MAX_LEN];
    logic [7:0]        out_byte;
    logic              accept, rd_end;

    assign accept = in_valid && in_ready;
    assign rd_end = rd && (idx == len_q + IW'(RX_HDR_BYTES - 1));
    assign pidx   = idx - IW'(RX_HDR_BYTES);
    assign size16 = 16'(len_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        in_ready = 1'b1;
        irq      = 1'b0;
        unique case (state)
            RX_EMPTY: if (in_valid) nxt = in_last ? RX_PEND : RX_FILL;
            RX_FILL:  if (in_valid && in_last) nxt = RX_PEND;
            RX_PEND: begin
                in_ready = 1'b0;
                irq      = 1'b1;
                if (rd_end) nxt = RX_EMPTY;
            end
            default: nxt = RX_EMPTY;
        endcase
    end

    always_comb begin
        if      (idx == IW'(0)) out_byte = size16[7:0];
        else if (idx == IW'(1)) out_byte = size16[15:8];
        else if (idx == IW'(2)) out_byte = 8'(port_q);
        else if (idx == IW'(3)) out_byte = vlan_q[7:0];
        else if (idx == IW'(4)) out_byte = vlan_q[15:8];
        else                    out_byte = mem[pidx[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            idx      <= '0;
            port_q   <= '0;
            vlan_q   <= '0;
            rdata    <= '0;
            underrun <= 1'b0;
        end else begin
            if (accept) begin
                if (state == RX_EMPTY) begin
                    port_q <= in_port;
                    vlan_q <= in_vlan;
                    len_q  <= IW'(1);
                end else if (len_q < IW'(MAX_LEN)) begin
                    len_q <= len_q + IW'(1);
                end
            end
            rdata <= 8'h00;
            if (rd) begin
                if (state == RX_PEND) begin
                    rdata <= out_byte;
                    idx   <= rd_end ? '0 : idx + IW'(1);
                end else begin
                    underrun <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept && state == RX_EMPTY)         mem[0] <= in_data;
        else if (accept && len_q < IW'(MAX_LEN)) mem[len_q[AW-1:0]] <= in_data;
    end

    assert_len_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= IW'(MAX_LEN));
    assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !rd |=> irq);
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !irq |=> rdata == 8'h00 && underrun);
    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/mbx_cpu_frame_port.sv
module mbx_cpu_frame_port
    import mbx_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int CTRL_MAX = 40,
    parameter int MIN_LEN  = 64,
    parameter int PORT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_irq,
    output logic              data_underrun,
    output logic              ctrl_underrun,
    output logic              fwd_valid,
    output logic [7:0]        fwd_data,
    output logic              fwd_last,
    output logic [PORT_W-1:0] fwd_port,
    output logic [7:0]        fwd_status,
    input  logic              sw_valid,
    input  logic [7:0]        sw_data,
    input  logic              sw_last,
    input  logic [PORT_W-1:0] sw_port,
    input  logic [15:0]       sw_vlan,
    output logic              sw_ready,
    input  logic              cf_valid,
    input  logic [7:0]        cf_data,
    input  logic              cf_last,
    input  logic [PORT_W-1:0] cf_port,
    output logic              cf_ready
);
    localparam logic [2:0] ADDR_FRAME = 3'b011;
    localparam logic [2:0] ADDR_CTRL  = 3'b111;

    logic sel_frame, sel_ctrl;
    logic irq_frame, irq_ctrl;
    logic [7:0] rdata_frame, rdata_ctrl;

    assign sel_frame = (host_addr == ADDR_FRAME);
    assign sel_ctrl  = (host_addr == ADDR_CTRL);

    mbx_tx_assembler #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .PORT_W(PORT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(host_wr && sel_frame), .wdata(host_wdata),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last),
        .fwd_port(fwd_port), .fwd_status(fwd_status)
    );

    mbx_rx_presenter #(.MAX_LEN(DEPTH), .PORT_W(PORT_W)) u_rx_frame (
        .clk(clk), .rst_n(rst_n), .in_valid(sw_valid), .in_data(sw_data),
        .in_last(sw_last), .in_port(sw_port), .in_vlan(sw_vlan), .in_ready(sw_ready),
        .rd(host_rd && sel_frame), .rdata(rdata_frame), .irq(irq_frame),
        .underrun(data_underrun)
    );

    mbx_rx_presenter #(.MAX_LEN(CTRL_MAX), .PORT_W(PORT_W)) u_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(cf_valid), .in_data(cf_data),
        .in_last(cf_last), .in_port(cf_port), .in_vlan(16'h0000), .in_ready(cf_ready),
        .rd(host_rd && sel_ctrl), .rdata(rdata_ctrl), .irq(irq_ctrl),
        .underrun(ctrl_underrun)
    );

    assign host_rdata = rdata_frame | rdata_ctrl;
    assign host_irq   = irq_frame | irq_ctrl;

    assert_one_read_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdata_frame != 8'h00 && rdata_ctrl != 8'h00));
    assert_irq_follows_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_ready |-> host_irq);
endmodule

// File: tb/mbx_cpu_frame_port_bench.sv
module mbx_cpu_frame_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_irq, data_underrun, ctrl_underrun;
    logic        fwd_valid, fwd_last;
    logic [7:0]  fwd_data, fwd_status;
    logic [2:0]  fwd_port;
    logic        sw_valid = 1'b0, sw_last = 1'b0;
    logic [7:0]  sw_data = '0;
    logic [2:0]  sw_port = '0;
    logic [15:0] sw_vlan = '0;
    logic        sw_ready;
    logic        cf_valid = 1'b0, cf_last = 1'b0;
    logic [7:0]  cf_data = '0;
    logic [2:0]  cf_port = '0;
    logic        cf_ready;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [19:0] exp_q[$];

    always #4 clk = ~clk;

    mbx_cpu_frame_port u_mbx_cpu_frame_port (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 7);
    endfunction

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // driver: queue expected output bytes, then write header and payload
    task automatic send_tx(input logic [2:0] port, input logic [7:0] st, input int len, input int seed);
        int n;
        n = (len < 64) ? 64 : len;
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == n - 1), port, st, (i < len) ? pat(seed, i) : 8'h00});
        hwr(3'd3, 8'(len)); hwr(3'd3, 8'(len >> 8)); hwr(3'd3, {5'd0, port}); hwr(3'd3, st);
        for (int i = 0; i < len; i++) hwr(3'd3, pat(seed, i));
    endtask

    task automatic drain_tx(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(req, exp_q.size(), 0);
    endtask

    // monitor: compare every forwarded byte against the scoreboard
    always @(negedge clk) begin
        if (rst_n && fwd_valid) begin
            if (exp_q.size() == 0) chk("R4 unexpected forward", 1, 0);
            else chk("R2/R3 forwarded byte", {fwd_last, fwd_port, fwd_status, fwd_data}, exp_q.pop_front());
        end
    end

    task automatic push_sw(input logic [2:0] port, input logic [15:0] vlan, input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            sw_valid = 1'b1; sw_data = pat(seed, i); sw_last = (i == len - 1);
            sw_port = port; sw_vlan = vlan;
        end
        @(negedge clk);
        sw_valid = 1'b0; sw_last = 1'b0;
    endtask

    task automatic push_cf(input logic [2:0] port, input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cf_valid = 1'b1; cf_data = pat(seed, i); cf_last = (i == len - 1); cf_port = port;
        end
        @(negedge clk);
        cf_valid = 1'b0; cf_last = 1'b0;
    endtask

    // reads header and payload; leaves the final payload byte for the caller when keep_last
    task automatic read_rx(input logic [2:0] a, input string req, input logic [2:0] port,
                           input logic [15:0] vlan, input int len, input int seed, input bit keep_last);
        logic [7:0] d;
        hrd(a, d); chk({req, " size lo"}, d, 8'(len));
        hrd(a, d); chk({req, " size hi"}, d, 8'(len >> 8));
        hrd(a, d); chk({req, " port"}, d, {5'd0, port});
        hrd(a, d); chk({req, " vlan lo"}, d, vlan[7:0]);
        hrd(a, d); chk({req, " vlan hi"}, d, vlan[15:8]);
        for (int i = 0; i < len - (keep_last ? 1 : 0); i++) begin
            hrd(a, d); chk({req, " payload"}, d, pat(seed, i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", host_irq, 0);
        chk("R1 fwd_valid", fwd_valid, 0);
        chk("R1 underruns", {data_underrun, ctrl_underrun}, 0);
        chk("R1 ready", {sw_ready, cf_ready}, 2'b11);
        chk("R1 rdata", host_rdata, 0);

        hrd(3'd3, d);
        chk("R8 empty read", d, 0);
        chk("R8 data_underrun", data_underrun, 1);
        chk("R8 ctrl untouched", ctrl_underrun, 0);
        hrd(3'd5, d);
        chk("R6 unmapped read", d, 0);

        send_tx(3'd5, 8'h3C, 70, 11); drain_tx("R2 long frame");
        send_tx(3'd2, 8'h81, 10, 40); drain_tx("R3 short frame padded");
        send_tx(3'd7, 8'h00, 0, 0);   drain_tx("R3 zero size frame");
        send_tx(3'd1, 8'h55, 20, 90);
        hwr(3'd3, 8'hAA); hwr(3'd3, 8'hBB); hwr(3'd3, 8'hCC);
        drain_tx("R4 writes during send");
        hwr(3'd7, 8'h05); hwr(3'd7, 8'h00); hwr(3'd1, 8'h09); hwr(3'd7, 8'h44);
        send_tx(3'd4, 8'h12, 65, 3); drain_tx("R4 frame after ignored writes");

        push_sw(3'd2, 16'h0A81, 12, 5);
        chk("R5 irq after frame", host_irq, 1);
        chk("R5 sw_ready low", sw_ready, 0);
        read_rx(3'd3, "R6", 3'd2, 16'h0A81, 12, 5, 1'b1);
        chk("R7 irq held before last", host_irq, 1);
        hrd(3'd3, d); chk("R6 last payload", d, pat(5, 11));
        chk("R7 irq released", host_irq, 0);
        chk("R7 ready back", sw_ready, 1);
        push_sw(3'd6, 16'hBEEF, 3, 77);
        chk("R7 irq re-asserts", host_irq, 1);
        read_rx(3'd3, "R7 second frame", 3'd6, 16'hBEEF, 3, 77, 1'b0);
        chk("R7 irq after second", host_irq, 0);

        push_cf(3'd6, 45, 21);
        chk("R9 irq for control", host_irq, 1);
        read_rx(3'd7, "R9 control", 3'd6, 16'h0000, 40, 21, 1'b0);
        chk("R9 irq after control", host_irq, 0);
        chk("R8 ctrl clear before", ctrl_underrun, 0);
        hrd(3'd7, d);
        chk("R8 ctrl empty read", d, 0);
        chk("R8 ctrl_underrun", ctrl_underrun, 1);

        push_sw(3'd3, 16'h0102, 4, 60);
        push_cf(3'd1, 2, 33);
        read_rx(3'd3, "R10 data", 3'd3, 16'h0102, 4, 60, 1'b0);
        chk("R10 irq held by control", host_irq, 1);
        read_rx(3'd7, "R10 control", 3'd1, 16'h0000, 2, 33, 1'b0);
        chk("R10 irq clear", host_irq, 0);
        chk("R8 sticky data", data_underrun, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule